// File: doc/BRIEF.md
# NAND Sector Bit-Error Correction Sequencer

This block repairs a 528-byte NAND sector sitting in an on-chip buffer once an upstream 8-error BCH locator has found which message bits are wrong. The buffer is organised as 264 words of 16 bits behind a synchronous single-port RAM port that the block drives. A one-cycle start strobe presents a correctable flag, an error count and eight 13-bit bit locations. The block captures them, turns each location into a buffer word address and a bit position, and flips that bit with a read-modify-write.

The sector is treated as a polynomial whose highest-order coefficient sits in buffer word 0. Inside a word the message order is the low byte from bit 7 down, then the high byte from bit 15 down. A location therefore maps to word `263 - floor(loc/16)` and to physical bit `(loc mod 16) XOR 8`. This is deliberately not a plain divide and modulo.

When a run ends, three sticky status bits report the result. Software clears each one by writing 1. The completion bit raises an interrupt only while its enable is high.

Top module: `nand_bitfix_seq`

## Requirements
- R1: A location L in 0..4223 addresses buffer word 263 - floor(L/16); location 3452 goes to word 48, 431 to word 237, 1062 to word 197, 1909 to word 144, 4223 to word 0.
- R2: The bit flipped inside the word is (L mod 16) XOR 8; the four locations above flip bits 4, 7, 14 and 13, and 4223 flips bit 7.
- R3: Every write carries the word read for that entry with exactly one bit inverted.
- R4: Entries are taken in index order 0 up to count-1, with entry k on loc_i[13k+12:13k]. A count of 0 completes without any RAM access.
- R5: Each entry is a read, one wait cycle for read data, then a write to the same address, and the next read follows that write. Two entries in one word therefore both take effect, and two entries on the same bit cancel.
- R6: If the correctable flag is 0 at start, nothing is written and status bits 0 (done) and 1 (uncorrectable) are set.
- R7: A count above 8, or a location of 4224 or more met at entry k, ends the run. Entries before k stay applied, nothing further is written, and status bits 0 and 2 (invalid) are set.
- R8: Status bits are sticky after a run completes. A 1 on the matching clear input bit clears a bit, and a set in the same cycle takes priority.
- R9: irq_o is high exactly when status bit 0 is set and irq_en_i is high.
- R10: busy_o rises the cycle after an accepted start and falls in the same cycle the status is posted. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle run request, sampled only when idle |
| correctable_i | input | 1 | Locator reports that all errors were found |
| err_cnt_i | input | 5 | Number of valid entries (0..8 legal) |
| loc_i | input | 104 | Eight 13-bit bit locations, entry k at [13k+12:13k] |
| irq_en_i | input | 1 | Enable for the completion interrupt |
| stat_clr_i | input | 3 | Write-1-to-clear strobes for the status bits |
| ram_en_o | output | 1 | Buffer access strobe |
| ram_we_o | output | 1 | Buffer write enable (with ram_en_o) |
| ram_addr_o | output | 9 | Buffer word address |
| ram_wdata_o | output | 16 | Buffer write data |
| ram_rdata_i | input | 16 | Buffer read data, valid the cycle after a read |
| busy_o | output | 1 | Run in progress |
| stat_o | output | 3 | Status: bit 0 done, bit 1 uncorrectable, bit 2 invalid |
| irq_o | output | 1 | Completion interrupt |

## Verification
The read-modify-write checks assume the buffer returns read data exactly one cycle after a read strobe and changes only through this block's own writes. The bench meets this with a behavioural RAM that answers on the next edge and is preloaded only while the block is idle. The inputs are taken to matter only in the start cycle. The bench pulses start for one cycle, and it changes the location inputs during a run only to show that a second start is ignored. Clear strobes are driven only between runs, apart from one check that relies on set winning over clear.

// File: rtl/bitfix_pkg.sv
package bitfix_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_EVAL   = 3'd1,
    SQ_READ   = 3'd2,
    SQ_WAIT   = 3'd3,
    SQ_WRITE  = 3'd4,
    SQ_FINISH = 3'd5
  } seq_state_t;

  localparam int ST_DONE  = 0;
  localparam int ST_UNCOR = 1;
  localparam int ST_INVAL = 2;
  localparam int ST_W     = 3;

endpackage

// File: rtl/bitfix_map.sv
module bitfix_map #(
  parameter int WORDS = 264,
  parameter int WW    = 16,
  parameter int LOCW  = 13,
  localparam int AW    = $clog2(WORDS),
  localparam int BW    = $clog2(WW),
  localparam int NBITS = WORDS * WW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LOCW-1:0] loc_i,
  output logic            ok_o,
  output logic [AW-1:0]   addr_o,
  output logic [WW-1:0]   mask_o
);

  logic [BW-1:0] bit_idx;
  logic [AW-1:0] word_from_lsb;

  assign ok_o          = (loc_i < LOCW'(NBITS));
  assign word_from_lsb = AW'(loc_i >> BW);
  assign addr_o        = AW'(WORDS - 1) - word_from_lsb;
  assign bit_idx       = loc_i[BW-1:0] ^ BW'(WW / 2);

  for (genvar j = 0; j < WW; j++) begin : g_mask
    assign mask_o[j] = (bit_idx == BW'(j));
  end

  AST_MAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (addr_o < AW'(WORDS))); // R1

  AST_MASK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_o) == 1); // R2

endmodule

// File: rtl/bitfix_ctrl.sv
module bitfix_ctrl
  import bitfix_pkg::*;
#(
  parameter int WORDS  = 264,
  parameter int WW     = 16,
  parameter int LOCW   = 13,
  parameter int MAXERR = 8,
  parameter int CNTW   = 5,
  localparam int AW   = $clog2(WORDS),
  localparam int SELW = $clog2(MAXERR),
  localparam int LVW  = MAXERR * LOCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            correctable_i,
  input  logic [CNTW-1:0] err_cnt_i,
  input  logic [LVW-1:0]  loc_i,
  output logic [LOCW-1:0] cur_loc_o,
  input  logic            map_ok_i,
  input  logic [AW-1:0]   map_addr_i,
  input  logic [WW-1:0]   map_mask_i,
  output logic            ram_en_o,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [WW-1:0]   ram_wdata_o,
  input  logic [WW-1:0]   ram_rdata_i,
  output logic            busy_o,
  output logic            fin_o,
  output logic            fin_uncor_o,
  output logic            fin_inval_o
);

  seq_state_t      st_q, st_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW-1:0] idx_q, idx_d;
  logic            corr_q, corr_d;
  logic [LVW-1:0]  loc_q, loc_d;
  logic [WW-1:0]   dat_q, dat_d;
  logic            unc_q, unc_d;
  logic            inv_q, inv_d;
  logic            cap_en;
  logic            dat_en;
  logic            idx_en;
  logic            flag_en;
  logic [LOCW-1:0] loc_arr [MAXERR];

  for (genvar k = 0; k < MAXERR; k++) begin : g_unpack
    assign loc_arr[k] = loc_q[k*LOCW +: LOCW];
  end

  assign cur_loc_o = loc_arr[idx_q[SELW-1:0]];

  always_comb begin
    st_d     = st_q;
    cnt_d    = err_cnt_i;
    corr_d   = correctable_i;
    loc_d    = loc_i;
    dat_d    = ram_rdata_i;
    idx_d    = idx_q;
    unc_d    = unc_q;
    inv_d    = inv_q;
    cap_en   = 1'b0;
    dat_en   = 1'b0;
    idx_en   = 1'b0;
    flag_en  = 1'b0;
    ram_en_o = 1'b0;
    ram_we_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          cap_en  = 1'b1;
          idx_en  = 1'b1;
          flag_en = 1'b1;
          idx_d   = '0;
          unc_d   = 1'b0;
          inv_d   = 1'b0;
          st_d    = SQ_EVAL;
        end
      end
      SQ_EVAL: begin
        if (!corr_q) begin
          flag_en = 1'b1;
          unc_d   = 1'b1;
          st_d    = SQ_FINISH;
        end else if (cnt_q > CNTW'(MAXERR)) begin
          flag_en = 1'b1;
          inv_d   = 1'b1;
          st_d    = SQ_FINISH;
        end else if (idx_q == cnt_q) begin
          st_d = SQ_FINISH;
        end else if (!map_ok_i) begin
          flag_en = 1'b1;
          inv_d   = 1'b1;
          st_d    = SQ_FINISH;
        end else begin
          st_d = SQ_READ;
        end
      end
      SQ_READ: begin
        ram_en_o = 1'b1;
        st_d     = SQ_WAIT;
      end
      SQ_WAIT: begin
        dat_en = 1'b1;
        st_d   = SQ_WRITE;
      end
      SQ_WRITE: begin
        ram_en_o = 1'b1;
        ram_we_o = 1'b1;
        idx_en   = 1'b1;
        idx_d    = idx_q + CNTW'(1);
        st_d     = SQ_EVAL;
      end
      SQ_FINISH: begin
        st_d = SQ_IDLE;
      end
      default: begin
        st_d = SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      corr_q <= 1'b0;
      loc_q  <= '0;
      dat_q  <= '0;
      idx_q  <= '0;
      unc_q  <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        cnt_q  <= cnt_d;
        corr_q <= corr_d;
        loc_q  <= loc_d;
      end
      if (dat_en) begin
        dat_q <= dat_d;
      end
      if (idx_en) begin
        idx_q <= idx_d;
      end
      if (flag_en) begin
        unc_q <= unc_d;
        inv_q <= inv_d;
      end
    end
  end

  assign ram_addr_o  = map_addr_i;
  assign ram_wdata_o = dat_q ^ map_mask_i;
  assign busy_o      = (st_q != SQ_IDLE);
  assign fin_o       = (st_q == SQ_FINISH);
  assign fin_uncor_o = unc_q;
  assign fin_inval_o = inv_q;

  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en_o && ram_we_o) |->
      ($past(ram_en_o && !ram_we_o, 2) && ($past(ram_addr_o, 2) == ram_addr_o))); // R5

  AST_SINGLE_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en_o && ram_we_o) |-> ($countones(ram_wdata_o ^ dat_q) == 1)); // R3

  AST_NO_ACCESS_UNCOR: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en_o |-> corr_q); // R6

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R10

  AST_ADDR_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en_o |-> (ram_addr_o < AW'(WORDS))); // R1

endmodule

// File: rtl/bitfix_irq.sv
module bitfix_irq
  import bitfix_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fin_i,
  input  logic            fin_uncor_i,
  input  logic            fin_inval_i,
  input  logic [ST_W-1:0] clr_i,
  input  logic            irq_en_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);

  logic [ST_W-1:0] stat_q, stat_d, set_v;
  logic            stat_en;

  always_comb begin
    set_v           = '0;
    set_v[ST_DONE]  = fin_i;
    set_v[ST_UNCOR] = fin_i & fin_uncor_i;
    set_v[ST_INVAL] = fin_i & fin_inval_i;
    stat_en         = fin_i | (|clr_i);
    stat_d          = (stat_q & ~clr_i) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q[ST_DONE] & irq_en_i;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[ST_DONE] && !fin_i) |=> !stat_o[ST_DONE]); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> stat_o[ST_DONE]); // R8

endmodule

// File: rtl/nand_bitfix_seq.sv
module nand_bitfix_seq
  import bitfix_pkg::*;
#(
  parameter int WORDS  = 264,
  parameter int WW     = 16,
  parameter int LOCW   = 13,
  parameter int MAXERR = 8,
  parameter int CNTW   = 5,
  localparam int AW  = $clog2(WORDS),
  localparam int LVW = MAXERR * LOCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            correctable_i,
  input  logic [CNTW-1:0] err_cnt_i,
  input  logic [LVW-1:0]  loc_i,
  input  logic            irq_en_i,
  input  logic [ST_W-1:0] stat_clr_i,
  output logic            ram_en_o,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [WW-1:0]   ram_wdata_o,
  input  logic [WW-1:0]   ram_rdata_i,
  output logic            busy_o,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);

  logic [LOCW-1:0] cur_loc;
  logic            map_ok;
  logic [AW-1:0]   map_addr;
  logic [WW-1:0]   map_mask;
  logic            fin, fin_uncor, fin_inval;

  bitfix_map #(.WORDS(WORDS), .WW(WW), .LOCW(LOCW)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .loc_i  (cur_loc),
    .ok_o   (map_ok),
    .addr_o (map_addr),
    .mask_o (map_mask)
  );

  bitfix_ctrl #(.WORDS(WORDS), .WW(WW), .LOCW(LOCW), .MAXERR(MAXERR), .CNTW(CNTW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .correctable_i (correctable_i),
    .err_cnt_i     (err_cnt_i),
    .loc_i         (loc_i),
    .cur_loc_o     (cur_loc),
    .map_ok_i      (map_ok),
    .map_addr_i    (map_addr),
    .map_mask_i    (map_mask),
    .ram_en_o      (ram_en_o),
    .ram_we_o      (ram_we_o),
    .ram_addr_o    (ram_addr_o),
    .ram_wdata_o   (ram_wdata_o),
    .ram_rdata_i   (ram_rdata_i),
    .busy_o        (busy_o),
    .fin_o         (fin),
    .fin_uncor_o   (fin_uncor),
    .fin_inval_o   (fin_inval)
  );

  bitfix_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fin_i       (fin),
    .fin_uncor_i (fin_uncor),
    .fin_inval_i (fin_inval),
    .clr_i       (stat_clr_i),
    .irq_en_i    (irq_en_i),
    .stat_o      (stat_o),
    .irq_o       (irq_o)
  );

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ram_en_o); // R10

endmodule

// File: tb/sim_nand_bitfix_seq.sv
module sim_nand_bitfix_seq;

  localparam int WORDS = 264;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         corr = 1'b0;
  logic [4:0]   cnt = '0;
  logic [103:0] locv = '0;
  logic         irq_en = 1'b0;
  logic [2:0]   clr = '0;
  logic         ram_en, ram_we;
  logic [8:0]   ram_addr;
  logic [15:0]  ram_wdata;
  logic [15:0]  ram_rdata;
  logic         busy, irq;
  logic [2:0]   stat;

  logic [15:0]  mem [WORDS];
  logic [15:0]  expv [WORDS];
  logic         fill_req = 1'b0;
  logic         wr_clr = 1'b0;
  int           wr_cnt;
  int           checks = 0;
  int           errors = 0;

  always #2.5 clk = ~clk;

  nand_bitfix_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .correctable_i(corr),
    .err_cnt_i(cnt), .loc_i(locv), .irq_en_i(irq_en), .stat_clr_i(clr),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .busy_o(busy), .stat_o(stat), .irq_o(irq)
  );

  function automatic logic [15:0] pat(int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= pat(i);
    end else if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
    if (wr_clr) wr_cnt <= 0;
    else if (ram_en && ram_we) wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fill();
    @(negedge clk);
    fill_req = 1'b1;
    wr_clr = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    wr_clr = 1'b0;
    for (int i = 0; i < WORDS; i++) expv[i] = pat(i);
  endtask

  task automatic flip_exp(input int loc);
    int w, b;
    w = 263 - loc / 16;
    b = (loc % 16) ^ 8;
    expv[w][b] = ~expv[w][b];
  endtask

  task automatic cmp_image(input string req);
    int bad, first;
    bad = 0;
    first = -1;
    for (int i = 0; i < WORDS; i++) begin
      if (mem[i] !== expv[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) chk(1'b1, req, "buffer image", 0, 0);
    else chk(1'b0, req, $sformatf("buffer word %0d", first), 32'(mem[first]), 32'(expv[first]));
  endtask

  task automatic clear_stat();
    @(negedge clk);
    clr = 3'b111;
    @(negedge clk);
    clr = 3'b000;
  endtask

  task automatic launch(input bit c, input int n, input int l[8]);
    @(negedge clk);
    for (int k = 0; k < 8; k++) locv[k*13 +: 13] = 13'(l[k]);
    corr = c;
    cnt = 5'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10", "busy after start", 32'(busy), 1);
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (busy === 1'b1 && t < 1000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 1000, "R10", "run completes", 32'(t), 0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R10", "reset busy", 32'(busy), 0);
    chk(stat === 3'b000, "R8", "reset status", 32'(stat), 0);
    chk(irq === 1'b0, "R9", "reset irq", 32'(irq), 0);
    chk(ram_en === 1'b0, "R4", "reset ram_en", 32'(ram_en), 0);
  endtask

  task automatic t_example();
    fill();
    irq_en = 1'b1;
    launch(1'b1, 4, '{431, 1062, 1909, 3452, 0, 0, 0, 0});
    wait_idle();
    chk(mem[48] === (pat(48) ^ 16'h0010), "R1", "loc 3452 word 48 bit 4", 32'(mem[48]), 32'(pat(48) ^ 16'h0010));
    chk(mem[237] === (pat(237) ^ 16'h0080), "R2", "loc 431 word 237 bit 7", 32'(mem[237]), 32'(pat(237) ^ 16'h0080));
    chk(mem[197] === (pat(197) ^ 16'h4000), "R2", "loc 1062 word 197 bit 14", 32'(mem[197]), 32'(pat(197) ^ 16'h4000));
    chk(mem[144] === (pat(144) ^ 16'h2000), "R1", "loc 1909 word 144 bit 13", 32'(mem[144]), 32'(pat(144) ^ 16'h2000));
    flip_exp(431); flip_exp(1062); flip_exp(1909); flip_exp(3452);
    cmp_image("R3");
    chk(wr_cnt == 4, "R4", "write count", 32'(wr_cnt), 4);
    chk(stat === 3'b001, "R8", "done only", 32'(stat), 1);
    chk(irq === 1'b1, "R9", "irq enabled", 32'(irq), 1);
    @(negedge clk);
    clr = 3'b001;
    @(negedge clk);
    clr = 3'b000;
    chk(stat === 3'b000, "R8", "w1c clears done", 32'(stat), 0);
    chk(irq === 1'b0, "R9", "irq after clear", 32'(irq), 0);
  endtask

  task automatic t_same_word();
    fill();
    launch(1'b1, 3, '{0, 1, 0, 0, 0, 0, 0, 0});
    wait_idle();
    chk(mem[263] === (pat(263) ^ 16'h0200), "R5", "same word twice, same bit cancels", 32'(mem[263]), 32'(pat(263) ^ 16'h0200));
    chk(wr_cnt == 3, "R5", "write count", 32'(wr_cnt), 3);
    clear_stat();
  endtask

  task automatic t_bounds();
    fill();
    launch(1'b1, 1, '{4223, 0, 0, 0, 0, 0, 0, 0});
    wait_idle();
    chk(mem[0] === (pat(0) ^ 16'h0080), "R1", "loc 4223 word 0 bit 7", 32'(mem[0]), 32'(pat(0) ^ 16'h0080));
    clear_stat();
    fill();
    launch(1'b1, 0, '{5, 6, 7, 8, 9, 10, 11, 12});
    wait_idle();
    chk(wr_cnt == 0, "R4", "count 0 no writes", 32'(wr_cnt), 0);
    chk(stat === 3'b001, "R4", "count 0 completes", 32'(stat), 1);
    cmp_image("R4");
    clear_stat();
  endtask

  task automatic t_uncor();
    fill();
    launch(1'b0, 4, '{431, 1062, 1909, 3452, 0, 0, 0, 0});
    wait_idle();
    chk(wr_cnt == 0, "R6", "no writes", 32'(wr_cnt), 0);
    chk(stat === 3'b011, "R6", "uncorrectable status", 32'(stat), 3);
    cmp_image("R6");
    clear_stat();
  endtask

  task automatic t_invalid();
    fill();
    launch(1'b1, 9, '{1, 2, 3, 4, 5, 6, 7, 8});
    wait_idle();
    chk(wr_cnt == 0, "R7", "count 9 no writes", 32'(wr_cnt), 0);
    chk(stat === 3'b101, "R7", "count 9 invalid", 32'(stat), 5);
    clear_stat();
    fill();
    launch(1'b1, 4, '{100, 200, 4224, 300, 0, 0, 0, 0});
    wait_idle();
    flip_exp(100); flip_exp(200);
    cmp_image("R4");
    chk(wr_cnt == 2, "R7", "abort after two entries", 32'(wr_cnt), 2);
    chk(stat === 3'b101, "R7", "bad location invalid", 32'(stat), 5);
    clear_stat();
  endtask

  task automatic t_busy_ignore();
    fill();
    launch(1'b1, 4, '{431, 1062, 1909, 3452, 0, 0, 0, 0});
    @(negedge clk);
    locv = '0;
    locv[12:0] = 13'd5;
    cnt = 5'd1;
    corr = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    flip_exp(431); flip_exp(1062); flip_exp(1909); flip_exp(3452);
    cmp_image("R10");
    chk(wr_cnt == 4, "R10", "second start ignored", 32'(wr_cnt), 4);
    @(negedge clk);
    chk(busy === 1'b0, "R10", "stays idle", 32'(busy), 0);
    clear_stat();
  endtask

  task automatic t_mask();
    irq_en = 1'b0;
    launch(1'b1, 0, '{0, 0, 0, 0, 0, 0, 0, 0});
    wait_idle();
    chk(stat[0] === 1'b1 && irq === 1'b0, "R9", "masked irq", 32'(irq), 0);
    irq_en = 1'b1;
    #1;
    chk(irq === 1'b1, "R9", "irq after enable", 32'(irq), 1);
    clear_stat();
    launch(1'b1, 0, '{0, 0, 0, 0, 0, 0, 0, 0});
    clr = 3'b001;
    wait_idle();
    clr = 3'b000;
    chk(stat[0] === 1'b1, "R8", "set beats clear", 32'(stat), 1);
    clear_stat();
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_same_word();
    t_bounds();
    t_uncor();
    t_invalid();
    t_busy_ignore();
    t_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule